// File: doc/BRIEF.md
# Start-up and Hiccup Fault Supervisor

This block is the supervisory state machine of an offline switching controller. It turns filtered supply-threshold flags into four actions: when switching may run, when the start-up FET that charges the supply is shut off, when the soft-start ramp is held in reset, and which operating state the controller is in. The supply comparators and the start-up circuit are outside the block. Its inputs are three level flags: supply above the turn-on level, supply above the minimum operating level, and supply above the logic-reset level. It also takes a current-limit flag and an over-voltage fault pulse.

A sustained current limit is confirmed by an overload timer. The block then stops switching and waits for a fixed number of supply charge/discharge cycles rather than a timed delay, and after that it restarts with a fresh soft-start. An over-voltage fault stops switching permanently. The start-up FET still cycles to keep the supply alive, and only a collapse of the supply below the logic-reset level clears the fault.

Top module: `supply_fault_supervisor`

## Requirements
- R1: After reset the outputs are: drive enable 0, start-up FET disable 0, soft-start reset 1, state code 0 (OFF).
- R2: In OFF, if the turn-on flag is sampled high (logic-reset flag high, no fault pulse), the next cycle is in RUN (state code 1) with drive enable 1.
- R3: The start-up FET disable output goes to 1 the cycle after the turn-on flag is sampled high. It goes to 0 the cycle after either the minimum-operating flag or the logic-reset flag is sampled low. Otherwise it holds its value.
- R4: In RUN, if the minimum-operating flag is sampled low, the next cycle is in OFF with drive enable 0.
- R5: In RUN, a sampled current-limit flag arms an overload timer of OL_TICKS cycles. If the flag is still high in the timer's last cycle, the block enters HICCUP (state code 2) one edge later, exactly OL_TICKS+1 edges after arming, with drive enable 0.
- R6: If the current-limit flag is low in the timer's last cycle, the block stays in RUN and the timer disarms until the flag is seen again.
- R7: In HICCUP, rising edges of the turn-on flag are counted. Edges before the HICCUP_CYCLES-th one leave the drive off. On the HICCUP_CYCLES-th edge the block returns to RUN in the next cycle.
- R8: A fault pulse sampled while the logic-reset flag is high moves the block from any state to OVP (state code 3) in the next cycle, with drive enable 0.
- R9: In OVP, switching never resumes while the logic-reset flag stays high, whatever the turn-on flag does. The start-up FET disable keeps following R3.
- R10: The logic-reset flag sampled low forces OFF in the next cycle. This takes priority over everything and is the only way out of OVP.
- R11: Soft-start reset is always the inverse of drive enable, so each return to RUN starts a fresh ramp.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vcc_on_i | input | 1 | Supply above turn-on level |
| vcc_min_i | input | 1 | Supply above minimum operating level |
| vcc_rst_i | input | 1 | Supply above logic-reset level |
| ilim_i | input | 1 | Cycle-by-cycle current limit active |
| ovp_i | input | 1 | Over-voltage fault pulse |
| drv_en_o | output | 1 | Switching allowed |
| startup_off_o | output | 1 | Start-up FET disable |
| ss_reset_o | output | 1 | Soft-start held in reset |
| state_o | output | 2 | State code: 0 OFF, 1 RUN, 2 HICCUP, 3 OVP |

## Verification
The bench targets the overload timer's last cycle. It checks that the drive is still on one edge before the trip and off exactly one edge after, so an off-by-one timer shows up as an early or late shutdown. A short current-limit blip must not trip at expiry; a design that latched the first event would go to hiccup here. The hiccup restart is swept edge by edge, which catches counters that restart after three or five supply cycles. In OVP the supply is cycled repeatedly to catch a design that re-enables switching on a turn-on edge, and a low logic-reset flag must then clear the latch.

// File: rtl/sfs_pkg.sv
package sfs_pkg;
  typedef enum logic [1:0] {
    SFS_OFF    = 2'd0,
    SFS_RUN    = 2'd1,
    SFS_HICCUP = 2'd2,
    SFS_OVP    = 2'd3
  } sfs_state_e;
endpackage

// File: rtl/sfs_startup_ctl.sv
module sfs_startup_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic vcc_on,
  input  logic vcc_min,
  input  logic vcc_rst,
  output logic startup_off,
  output logic on_rise
);
  logic off_q, off_d, off_en;
  logic von_q;

  always_comb begin
    off_en = 1'b0;
    off_d  = off_q;
    if (!vcc_rst || !vcc_min) begin
      off_en = 1'b1;
      off_d  = 1'b0;
    end else if (vcc_on) begin
      off_en = 1'b1;
      off_d  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off_q <= 1'b0;
      von_q <= 1'b0;
    end else begin
      if (off_en) off_q <= off_d;
      von_q <= vcc_on;
    end
  end

  assign startup_off = off_q;
  assign on_rise     = vcc_on & ~von_q;

  // R3
  startup_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!vcc_min || !vcc_rst) |=> !startup_off);
  // R3
  startup_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vcc_rst && vcc_min && vcc_on) |=> startup_off);
endmodule

// File: rtl/sfs_overload_timer.sv
module sfs_overload_timer #(
  parameter int OL_TICKS = 12000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic ilim,
  output logic trip
);
  localparam int OLW = (OL_TICKS > 1) ? $clog2(OL_TICKS) : 1;
  localparam logic [OLW-1:0] OL_LAST = OLW'(OL_TICKS - 1);

  logic           active_q, active_d;
  logic [OLW-1:0] cnt_q, cnt_d;
  logic           last;

  assign last = active_q && (cnt_q == OL_LAST);
  assign trip = last && ilim;

  always_comb begin
    active_d = active_q;
    cnt_d    = cnt_q;
    if (!arm) begin
      active_d = 1'b0;
      cnt_d    = '0;
    end else if (!active_q) begin
      if (ilim) begin
        active_d = 1'b1;
        cnt_d    = '0;
      end
    end else if (last) begin
      active_d = 1'b0;
      cnt_d    = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else begin
      active_q <= active_d;
      cnt_q    <= cnt_d;
    end
  end

  // R5
  timer_disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !arm |=> (!active_q && cnt_q == '0));
  // R6
  timer_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (arm && last && !ilim) |=> !active_q);
endmodule

// File: rtl/sfs_hiccup_counter.sv
module sfs_hiccup_counter #(
  parameter int HICCUP_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic rise,
  output logic done
);
  localparam int CW = (HICCUP_CYCLES > 1) ? $clog2(HICCUP_CYCLES) : 1;
  localparam logic [CW-1:0] C_LAST = CW'(HICCUP_CYCLES - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign done = en && rise && (cnt_q == C_LAST);

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (!en) begin
      cnt_en = 1'b1;
      cnt_d  = '0;
    end else if (rise && cnt_q != C_LAST) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // R7
  hiccup_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !rise) |=> $stable(cnt_q));
  // R7
  hiccup_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> cnt_q == '0);
endmodule

// File: rtl/supply_fault_supervisor.sv
module supply_fault_supervisor
  import sfs_pkg::*;
#(
  parameter int OL_TICKS      = 12000,
  parameter int HICCUP_CYCLES = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       vcc_on_i,
  input  logic       vcc_min_i,
  input  logic       vcc_rst_i,
  input  logic       ilim_i,
  input  logic       ovp_i,
  output logic       drv_en_o,
  output logic       startup_off_o,
  output logic       ss_reset_o,
  output logic [1:0] state_o
);
  sfs_state_e state_q, state_d;
  logic       on_rise, ol_trip, hic_done;

  sfs_startup_ctl u_startup (
    .clk        (clk),
    .rst_n      (rst_n),
    .vcc_on     (vcc_on_i),
    .vcc_min    (vcc_min_i),
    .vcc_rst    (vcc_rst_i),
    .startup_off(startup_off_o),
    .on_rise    (on_rise)
  );

  sfs_overload_timer #(.OL_TICKS(OL_TICKS)) u_ol_timer (
    .clk  (clk),
    .rst_n(rst_n),
    .arm  (state_q == SFS_RUN),
    .ilim (ilim_i),
    .trip (ol_trip)
  );

  sfs_hiccup_counter #(.HICCUP_CYCLES(HICCUP_CYCLES)) u_hiccup (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (state_q == SFS_HICCUP),
    .rise (on_rise),
    .done (hic_done)
  );

  always_comb begin
    state_d = state_q;
    if (!vcc_rst_i) begin
      state_d = SFS_OFF;
    end else if (ovp_i) begin
      state_d = SFS_OVP;
    end else begin
      unique case (state_q)
        SFS_OFF:    if (vcc_on_i) state_d = SFS_RUN;
        SFS_RUN: begin
          if (!vcc_min_i)   state_d = SFS_OFF;
          else if (ol_trip) state_d = SFS_HICCUP;
        end
        SFS_HICCUP: if (hic_done) state_d = SFS_RUN;
        SFS_OVP:    state_d = SFS_OVP;
        default:    state_d = SFS_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SFS_OFF;
    else        state_q <= state_d;
  end

  assign drv_en_o   = (state_q == SFS_RUN);
  assign ss_reset_o = (state_q != SFS_RUN);
  assign state_o    = state_q;

  // R8
  ovp_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vcc_rst_i && ovp_i) |=> (state_q == SFS_OVP && !drv_en_o));
  // R9
  ovp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SFS_OVP && vcc_rst_i) |=> !drv_en_o);
  // R10
  rst_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !vcc_rst_i |=> (state_q == SFS_OFF));
  // R4
  uvlo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SFS_RUN && vcc_rst_i && !ovp_i && !vcc_min_i) |=> !drv_en_o);
  // R11
  ss_fresh_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drv_en_o) |-> $past(ss_reset_o));
endmodule

// File: tb/supply_fault_supervisor_tb.sv
module supply_fault_supervisor_tb;
  localparam int CLK_PERIOD = 10;
  localparam int OL = 8;
  localparam int HC = 4;

  logic clk = 1'b0;
  logic rst_n, vcc_on, vcc_min, vcc_rst, ilim, ovp;
  logic drv_en, startup_off, ss_reset;
  logic [1:0] state;
  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  supply_fault_supervisor #(.OL_TICKS(OL), .HICCUP_CYCLES(HC)) u_dut (
    .clk(clk), .rst_n(rst_n), .vcc_on_i(vcc_on), .vcc_min_i(vcc_min),
    .vcc_rst_i(vcc_rst), .ilim_i(ilim), .ovp_i(ovp), .drv_en_o(drv_en),
    .startup_off_o(startup_off), .ss_reset_o(ss_reset), .state_o(state));

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // expected outputs derived from state code: drive only in RUN (1)
  task automatic chk_state(input string req, input int exp_state);
    chk({req, " state"}, state, exp_state);
    chk({req, " drv_en"}, drv_en, exp_state == 1 ? 1 : 0);
    chk({req, " ss_reset R11"}, ss_reset, exp_state == 1 ? 0 : 1);
  endtask

  task automatic supply_cycle(input string req, input int exp_state);
    vcc_on = 0; vcc_min = 0; tick(1);
    chk({req, " fet released R3"}, startup_off, 0);
    vcc_min = 1; tick(1);
    chk({req, " fet holds R3"}, startup_off, 0);
    vcc_on = 1; tick(1);
    chk({req, " fet set R3"}, startup_off, 1);
    chk_state(req, exp_state);
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks + 1 - fails, checks + 1);
    $finish;
  end

  initial begin
    rst_n = 0; vcc_on = 0; vcc_min = 0; vcc_rst = 0; ilim = 0; ovp = 0;
    tick(2);
    rst_n = 1; tick(1);
    chk_state("R1", 0);
    chk("R1 startup_off", startup_off, 0);

    vcc_rst = 1; vcc_min = 1; tick(1);
    chk("R3 hold below on", startup_off, 0);
    chk_state("R2 waits", 0);
    vcc_on = 1; tick(1);
    chk_state("R2 enable", 1);
    chk("R3 set", startup_off, 1);

    // short current-limit blip must not trip at expiry (R6)
    for (int w = 1; w <= 3; w++) begin
      ilim = 1; tick(w); ilim = 0;
      tick(OL + 2);
      chk_state("R6 blip no trip", 1);
    end

    // sustained current limit: drive on after OL edges, off after OL+1 (R5)
    ilim = 1; tick(OL);
    chk_state("R5 before expiry", 1);
    tick(1);
    chk_state("R5 trip", 2);
    ilim = 0;

    // hiccup: restart on the HC-th turn-on rising edge (R7)
    for (int c = 1; c <= HC; c++) begin
      supply_cycle("R7 hiccup", c < HC ? 2 : 1);
    end

    // undervoltage in RUN (R4)
    vcc_on = 0; vcc_min = 0; tick(1);
    chk_state("R4 uvlo", 0);
    chk("R4 fet released R3", startup_off, 0);
    vcc_min = 1; vcc_on = 1; tick(1);
    chk_state("R2 re-enable", 1);

    // OVP latch (R8, R9)
    ovp = 1; tick(1); ovp = 0;
    chk_state("R8 ovp", 3);
    for (int k = 0; k < 5; k++) supply_cycle("R9 ovp hold", 3);

    // logic-reset collapse clears OVP, and beats a fault pulse (R10)
    vcc_on = 0; vcc_min = 0; vcc_rst = 0; ovp = 1; tick(1); ovp = 0;
    chk_state("R10 clear", 0);
    chk("R10 fet released", startup_off, 0);
    vcc_rst = 1; vcc_min = 1; vcc_on = 1; tick(1);
    chk_state("R10 restart", 1);

    // OVP from HICCUP (R8)
    ilim = 1; tick(OL + 1); ilim = 0;
    chk_state("R5 second trip", 2);
    ovp = 1; tick(1); ovp = 0;
    chk_state("R8 ovp from hiccup", 3);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule